// File: doc/BRIEF.md
# Programmable-Slot Priority Resolver

This block picks, from a table of programmable priority slots, the most urgent active source on the normal interrupt path and the most urgent active source on the fast interrupt path. Urgency does not follow source number: software fills the slots with source IDs, and the slot index alone gives the order. Slot 0 is the most urgent.

The inputs are three things. The first is a vector of sources that are both pending and enabled. The second is a vector that routes each source to the fast path (1) or to the normal path (0). The third is the slot table, one 32-bit word per slot. The output is a single 32-bit status word. It reports both winners with their own valid flags, so a bus read of the controller can return it directly. The result is purely combinational. The block holds no storage, and the request lines are generated elsewhere.

Top module: `prio_slot_resolver`

## Requirements
- R1: A source is normal-path eligible when its bit in `act_i` is 1 and its bit in `fiq_route_i` is 0. The winner of the normal path is reported as bit 31 = 1, with its ID in bits 21:16 of `status_o`.
- R2: Among the qualifying slots naming an eligible source, the one with the lowest index decides the result. Several slots naming the same source give the same result as the lowest of them alone.
- R3: A source is fast-path eligible when its bits in `act_i` and `fiq_route_i` are both 1. The winner of the fast path is reported as bit 15 = 1, with its ID in bits 5:0.
- R4: A path with no winner reports its flag as 0 and its ID field as 0x3F. With no winner on either path the word is 0x003F003F.
- R5: Bits 30:22 and 14:6 of `status_o` are always 0.
- R6: Slot k is the word `slots_i[32k+31:32k]`. It qualifies only when bit 31 is 1 and bits 5:0 hold a value below NSRC. Bits 30:6 of a slot word have no effect.
- R7: Source ID n refers to bit n of `act_i` and `fiq_route_i`, so IDs 32 to 39 use the upper byte of the 40-bit vectors.
- R8: The two paths are resolved independently. A higher slot naming a fast-path source does not hide a normal-path source in a lower-urgency slot, and the reverse also holds.
- R9: `status_o` follows the inputs combinationally, with no clock edge between an input change and the new result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| act_i | input | NSRC | Pending-and-enabled flag per source |
| fiq_route_i | input | NSRC | 1 routes the source to the fast path, 0 to the normal path |
| slots_i | input | NSLOT*32 | Slot table, slot k in bits 32k+31:32k |
| status_o | output | 32 | Both winners with their valid flags |

## Verification
The bench builds the resolver with its default 40 sources and 40 slots. At these values the upper-bank IDs 32 to 39 can be reached, and a 6-bit ID field can name the out-of-range values 40 to 63. The random slot tables therefore mix valid and invalid slots, illegal IDs, junk in the ignored middle bits and repeated IDs. These tables are compared against a model that scans upward from slot 0. Directed cases pin down the empty word, bank selection and the independence of the two paths.

// File: rtl/prio_slot_resolver.sv
module prio_slot_resolver #(
  parameter int NSRC  = 40,
  parameter int NSLOT = 40
) (
  input  logic [NSRC-1:0]     act_i,
  input  logic [NSRC-1:0]     fiq_route_i,
  input  logic [NSLOT*32-1:0] slots_i,
  output logic [31:0]         status_o
);
  localparam int IDW  = 6;
  localparam int SPAN = 1 << IDW;
  localparam logic [IDW:0]   LIMIT = (IDW+1)'(NSRC);
  localparam logic [IDW-1:0] NONE  = '1;

  logic [SPAN-1:0] act_x, route_x;
  assign act_x   = SPAN'(act_i);
  assign route_x = SPAN'(fiq_route_i);

  logic [IDW-1:0] slot_id [NSLOT];
  logic [NSLOT-1:0] hit_irq, hit_fiq;

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    logic ok, unused_mid;
    assign slot_id[s]  = slots_i[s*32 +: IDW];
    assign ok          = slots_i[s*32+31] && ({1'b0, slot_id[s]} < LIMIT);
    assign hit_irq[s]  = ok && act_x[slot_id[s]] && !route_x[slot_id[s]];
    assign hit_fiq[s]  = ok && act_x[slot_id[s]] &&  route_x[slot_id[s]];
    assign unused_mid  = ^slots_i[s*32+IDW +: 31-IDW];
  end

  logic           irq_v, fiq_v;
  logic [IDW-1:0] irq_id, fiq_id;

  always_comb begin
    irq_v = 1'b0; irq_id = NONE;
    fiq_v = 1'b0; fiq_id = NONE;
    for (int s = NSLOT-1; s >= 0; s--) begin
      if (hit_irq[s]) begin irq_v = 1'b1; irq_id = slot_id[s]; end
      if (hit_fiq[s]) begin fiq_v = 1'b1; fiq_id = slot_id[s]; end
    end
  end

  assign status_o = {irq_v, 9'b0, irq_id, fiq_v, 9'b0, fiq_id};
endmodule

module prio_slot_resolver_chk #(
  parameter int NSRC  = 40,
  parameter int NSLOT = 40
) (
  input logic [NSRC-1:0]     act_i,
  input logic [NSRC-1:0]     fiq_route_i,
  input logic [NSLOT*32-1:0] slots_i,
  input logic [31:0]         status_o
);
  logic [63:0] act_x, route_x;
  logic [5:0]  s0_id, irq_id, fiq_id;
  assign act_x   = 64'(act_i);
  assign route_x = 64'(fiq_route_i);
  assign s0_id   = slots_i[5:0];
  assign irq_id  = status_o[21:16];
  assign fiq_id  = status_o[5:0];

  always_comb begin
    // R4
    irq_none_chk: assert (status_o[31] || irq_id == 6'h3F);
    // R4
    fiq_none_chk: assert (status_o[15] || fiq_id == 6'h3F);
    // R5
    reserved_zero_chk: assert (status_o[30:22] == '0 && status_o[14:6] == '0);
    // R1
    irq_win_active_chk: assert (!status_o[31] ||
      (32'(irq_id) < NSRC && act_x[irq_id] && !route_x[irq_id]));
    // R3
    fiq_win_active_chk: assert (!status_o[15] ||
      (32'(fiq_id) < NSRC && act_x[fiq_id] && route_x[fiq_id]));
    // R2
    slot0_first_chk: assert (!(slots_i[31] && 32'(s0_id) < NSRC && act_x[s0_id]) ||
      (route_x[s0_id] ? (status_o[15] && fiq_id == s0_id)
                      : (status_o[31] && irq_id == s0_id)));
  end
endmodule

bind prio_slot_resolver prio_slot_resolver_chk #(.NSRC(NSRC), .NSLOT(NSLOT)) u_chk (.*);

// File: tb/prio_slot_resolver_bench.sv
module prio_slot_resolver_bench;
  localparam int  NSRC = 40;
  localparam int  NSLOT = 40;
  localparam time CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NSRC-1:0]     act, route;
  logic [NSLOT*32-1:0] slots;
  logic [31:0]         status;
  int checks = 0, errors = 0, cycles = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_slot_resolver #(.NSRC(NSRC), .NSLOT(NSLOT)) u_prio_slot_resolver (
    .act_i(act), .fiq_route_i(route), .slots_i(slots), .status_o(status));

  function automatic logic [31:0] model(input logic [NSRC-1:0] a,
      input logic [NSRC-1:0] r, input logic [NSLOT*32-1:0] t);
    logic iv = 0, fv = 0;
    logic [5:0] ii = 6'h3F, fi = 6'h3F;
    for (int s = 0; s < NSLOT; s++) begin
      logic [5:0] id = t[s*32 +: 6];
      if (t[s*32+31] && int'(id) < NSRC && a[id]) begin
        if (r[id] && !fv) begin fv = 1; fi = id; end
        if (!r[id] && !iv) begin iv = 1; ii = id; end
      end
    end
    return {iv, 9'b0, ii, fv, 9'b0, fi};
  endfunction

  task automatic check(input string tag, input logic [31:0] exp);
    checks++;
    if (status !== exp) begin
      errors++;
      $display("FAIL %s: status=%08h expected=%08h", tag, status, exp);
    end
  endtask

  task automatic apply(input string tag, input logic [31:0] exp);
    @(posedge clk);
    #1;
    @(negedge clk);
    check(tag, exp);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++; errors++;
      $display("FAIL watchdog: cycles=%0d expected<=100000", cycles);
      finish_run();
    end
  end

  initial begin
    act = '0; route = '0; slots = '0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    // R4: nothing active
    apply("R4 empty", 32'h003F003F);
    // R1: slot 0 names normal source 5
    slots[31:0] = 32'h8000_0005; act[5] = 1;
    apply("R1 normal win", 32'h8005003F);
    // R2/R3: slots 1 and 3 name fast sources 9 and 7
    act = '0; slots = '0;
    slots[1*32 +: 32] = 32'h8000_0009; slots[3*32 +: 32] = 32'h8000_0007;
    act[9] = 1; act[7] = 1; route[9] = 1; route[7] = 1;
    apply("R2/R3 fast lowest slot", 32'h003F8009);
    // R7: upper bank source 39
    act = '0; route = '0; slots = '0;
    slots[31:0] = 32'h8000_0027; act[39] = 1;
    apply("R7 upper bank", 32'h8027003F);
    // R7: bit 39 routed fast
    route[39] = 1;
    apply("R7 upper bank fast", 32'h003F8027);
    // R6: out-of-range ID ignored
    act = '1; route = '0; slots = '0;
    slots[31:0] = 32'h8000_002D;
    apply("R6 id out of range", 32'h003F003F);
    // R6: valid flag clear, junk bits set
    slots[31:0] = 32'h7FFF_FFC5;
    apply("R6 invalid slot", 32'h003F003F);
    // R6: middle bits ignored
    slots[31:0] = 32'hBFFF_FFC5;
    apply("R6 middle bits ignored", 32'h8005003F);
    // R8: fast source in slot 0 does not hide normal source in slot 1
    act = '0; route = '0; slots = '0;
    slots[31:0] = 32'h8000_0002; slots[63:32] = 32'h8000_0003;
    act[2] = 1; act[3] = 1; route[2] = 1;
    apply("R8 independent paths", 32'h80038002);
    // R2: duplicate IDs
    slots[5*32 +: 32] = 32'h8000_0003; slots[7*32 +: 32] = 32'h8000_0002;
    apply("R2 duplicates", 32'h80038002);
    // R9: same-cycle response to an input change
    @(posedge clk);
    #2 act[3] = 0;
    #1 check("R9 combinational", 32'h003F8002);
    // R2: lower slot overtakes once its source becomes active
    act = '0; route = '0; slots = '0;
    slots[10*32 +: 32] = 32'h8000_0011; slots[4*32 +: 32] = 32'h8000_0021;
    act[17] = 1;
    apply("R2 only later slot", 32'h8011003F);
    act[33] = 1;
    apply("R2 earlier slot wins", 32'h8021003F);

    void'($urandom(32'd1234));
    for (int n = 0; n < 600; n++) begin
      for (int w = 0; w < NSLOT; w++) begin
        logic [31:0] v = $urandom;
        v[31] = ($urandom_range(3) != 0);
        v[5:0] = (n % 3 == 0) ? 6'($urandom_range(NSRC-1)) : 6'($urandom_range(63));
        slots[w*32 +: 32] = v;
      end
      act   = {$urandom, $urandom};
      route = {$urandom, $urandom};
      if (n % 4 == 1) act = act & {$urandom, $urandom} & {$urandom, $urandom};
      apply("R1/R2/R3/R5/R6 random", model(act, route, slots));
    end
    finish_run();
  end
endmodule